// File: doc/BRIEF.md
# Write-Busy Status Read Multiplexer

This block sits on the byte-wide read path of a nonvolatile memory model and lets a host find out whether an internal write cycle is still running. A write timer outside the block raises a busy flag for the length of each write cycle, including cycles started by writes that data protection rejects. While that flag is high, a read returns a status byte instead of array contents. In that byte one bit flips on every completed read and another carries the inverse of the top bit of the last byte written. Once busy drops, reads return stored data again and the flipping stops.

A read is the interval in which chip enable and output enable (both active low) are low together. The toggle advances when such a read ends, so one read gives exactly one flip. Each new write cycle, marked by a one-cycle start pulse that also captures the written byte, clears the toggle. The first status read of every cycle therefore returns 0 in the toggle bit. The output bus is driven only during a read. Outside a read an enable output tells the pad logic to float the bus.

Top module: `poll_status_mux`

## Requirements
- R1: `dout_en_o` is 1 exactly when `ce_n_i` and `oe_n_i` are both 0. With only one of them low, the bus stays undriven.
- R2: While `busy_i` is 1, bit 6 of `dout_o` is inverted after every completed read, meaning a clock edge at which both strobes were low on the previous edge and are no longer both low. Two consecutive busy reads therefore differ in bit 6.
- R3: A `wr_start_i` pulse clears the toggle from the next clock edge. The first read after it returns bit 6 = 0.
- R4: While `busy_i` is 1, bit 7 of `dout_o` equals the inverse of bit 7 of `wr_data_i` captured at the last `wr_start_i` pulse.
- R5: While `busy_i` is 1, bits 5..0 of `dout_o` equal the toggle bit when `FILL_OTHERS` is 1, and are 0 when it is 0 (the default).
- R6: While `busy_i` is 0, `dout_o` equals `arr_data_i`, and reads do not advance the toggle.
- R7: A strobe during which only one of `ce_n_i` or `oe_n_i` goes low is not a read and does not advance the toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy_i | input | 1 | Internal write cycle in progress, from the write timer |
| wr_start_i | input | 1 | One-cycle pulse at the start of each write cycle |
| wr_data_i | input | 8 | Byte written, captured on `wr_start_i` |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| arr_data_i | input | 8 | Data read from the storage array |
| dout_o | output | 8 | Read data or status byte |
| dout_en_o | output | 1 | Output bus drive enable, low means high impedance |

## Verification
`dout_o` and `dout_en_o` are combinational from the strobes, `busy_i` and the array data, so the bench samples them two nanoseconds after it drives an input, within the same cycle. The toggle and the captured poll bit change at the first rising edge after a read ends or after a start pulse. The bench therefore samples those values only after a full clock period has passed since the event, and it updates its model at the point where it ends the read. Random read, partial-strobe, write-start and busy-release actions are checked against a model function built from the requirements.

// File: rtl/poll_status_mux.sv
module poll_status_mux #(
  parameter int DATA_W      = 8,
  parameter int TOGGLE_POS  = 6,
  parameter int POLL_POS    = 7,
  parameter bit FILL_OTHERS = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic              wr_start_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic [DATA_W-1:0] arr_data_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_en_o
);

  logic              rd_now;
  logic              rd_q;
  logic              tgl_q;
  logic              poll_q;
  logic              rd_done;
  logic [DATA_W-1:0] status;
  logic              unused_wr;

  assign rd_now    = ~ce_n_i & ~oe_n_i;
  assign rd_done   = rd_q & ~rd_now;
  assign unused_wr = ^wr_data_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      tgl_q  <= 1'b0;
      poll_q <= 1'b0;
    end else begin
      rd_q <= rd_now;
      if (wr_start_i) begin
        tgl_q  <= 1'b0;
        poll_q <= ~wr_data_i[POLL_POS];
      end else if (busy_i && rd_done) begin
        tgl_q <= ~tgl_q;
      end
    end
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_status
    if (i == TOGGLE_POS) begin : g_tgl
      assign status[i] = tgl_q;
    end else if (i == POLL_POS) begin : g_poll
      assign status[i] = poll_q;
    end else if (FILL_OTHERS) begin : g_fill
      assign status[i] = tgl_q;
    end else begin : g_zero
      assign status[i] = 1'b0;
    end
  end

  assign dout_o    = busy_i ? status : arr_data_i;
  assign dout_en_o = rd_now;

endmodule

module poll_status_mux_chk #(
  parameter int DATA_W      = 8,
  parameter int TOGGLE_POS  = 6,
  parameter int POLL_POS    = 7,
  parameter bit FILL_OTHERS = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_i,
  input logic              wr_start_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              ce_n_i,
  input logic              oe_n_i,
  input logic [DATA_W-1:0] arr_data_i,
  input logic [DATA_W-1:0] dout_o,
  input logic              dout_en_o
);

  logic c_rd_q;
  logic c_poll;
  logic c_seen_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_rd_q       <= 1'b0;
      c_poll       <= 1'b0;
      c_seen_start <= 1'b0;
    end else begin
      c_rd_q <= ~ce_n_i & ~oe_n_i;
      if (wr_start_i) begin
        c_poll       <= ~wr_data_i[POLL_POS];
        c_seen_start <= 1'b1;
      end
    end
  end

  a_r1_no_drive_outside_read: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n_i | oe_n_i) |-> !dout_en_o);

  a_r2_flip_on_read_end: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !wr_start_i && c_rd_q && !(~ce_n_i & ~oe_n_i)) ##1 busy_i
      |-> dout_o[TOGGLE_POS] != $past(dout_o[TOGGLE_POS]));

  a_r2_hold_without_read_end: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !wr_start_i && !(c_rd_q && (ce_n_i | oe_n_i))) ##1 busy_i
      |-> $stable(dout_o[TOGGLE_POS]));

  a_r3_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start_i ##1 busy_i |-> dout_o[TOGGLE_POS] == 1'b0);

  a_r4_poll_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && c_seen_start && !$past(wr_start_i)) |-> dout_o[POLL_POS] == c_poll);

  a_r6_array_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |-> dout_o == arr_data_i);

endmodule

bind poll_status_mux poll_status_mux_chk #(
  .DATA_W(DATA_W), .TOGGLE_POS(TOGGLE_POS), .POLL_POS(POLL_POS), .FILL_OTHERS(FILL_OTHERS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .wr_start_i(wr_start_i),
  .wr_data_i(wr_data_i), .ce_n_i(ce_n_i), .oe_n_i(oe_n_i),
  .arr_data_i(arr_data_i), .dout_o(dout_o), .dout_en_o(dout_en_o)
);

// File: tb/poll_status_mux_bench.sv
`timescale 1ns/1ps
module poll_status_mux_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       busy = 1'b0;
  logic       wr_start = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       ce_n = 1'b1;
  logic       oe_n = 1'b1;
  logic [7:0] arr = 8'h00;
  logic [7:0] dout;
  logic       dout_en;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  bit m_tgl = 1'b0;
  bit m_poll = 1'b0;

  always #10 clk = ~clk;

  poll_status_mux u_poll_status_mux (
    .clk(clk), .rst_n(rst_n), .busy_i(busy), .wr_start_i(wr_start),
    .wr_data_i(wr_data), .ce_n_i(ce_n), .oe_n_i(oe_n),
    .arr_data_i(arr), .dout_o(dout), .dout_en_o(dout_en)
  );

  function automatic logic [7:0] exp_byte(bit b, bit t, bit p, logic [7:0] a);
    if (!b) return a;
    return {p, t, 6'b000000};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic do_read(string tag, output logic [7:0] got);
    @(negedge clk);
    if ($urandom_range(1)) ce_n = 1'b0; else oe_n = 1'b0;
    #2;
    chk({tag, " R1 single strobe"}, {7'd0, dout_en}, 8'd0);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0;
    #2;
    got = dout;
    chk("R1 read enable", {7'd0, dout_en}, 8'd1);
    chk(tag, dout, exp_byte(busy, m_tgl, m_poll, arr));
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
    if (busy) m_tgl = ~m_tgl;
    @(negedge clk);
  endtask

  task automatic start_write(logic [7:0] d);
    @(negedge clk);
    wr_start = 1'b1; wr_data = d; busy = 1'b1;
    @(negedge clk);
    wr_start = 1'b0;
    m_tgl = 1'b0; m_poll = ~d[7];
  endtask

  task automatic partial_strobe();
    @(negedge clk);
    if ($urandom_range(1)) ce_n = 1'b0; else oe_n = 1'b0;
    #2;
    chk("R1 partial strobe undriven", {7'd0, dout_en}, 8'd0);
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] r0, r1;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 reset undriven", {7'd0, dout_en}, 8'd0);
    rst_n = 1'b1;
    arr = 8'h3C;
    do_read("R6 idle read returns array", r0);

    start_write(8'hA5);
    do_read("R3 first busy read bit6=0, R4 bit7 inverted, R5 low bits zero", r0);
    chk("R3 first read toggle", {7'd0, r0[6]}, 8'd0);
    chk("R4 poll bit", {7'd0, r0[7]}, 8'd0);
    arr = 8'hFF;
    do_read("R2 second busy read", r1);
    chk("R2 consecutive busy reads differ in bit6", {7'd0, r0[6] ^ r1[6]}, 8'd1);
    partial_strobe();
    do_read("R7 partial strobe did not toggle", r0);
    chk("R7 bit6 after partial strobe", {7'd0, r0[6]}, 8'd0);
    start_write(8'h12);
    do_read("R3 restart clears toggle, R4 poll=1", r0);
    chk("R4 poll bit from 12", {7'd0, r0[7]}, 8'd1);
    @(negedge clk); busy = 1'b0;
    arr = 8'h5A;
    do_read("R6 ready returns array", r0);
    do_read("R6 bit6 stays with array", r1);
    chk("R6 no toggle after busy", {7'd0, r0[6] ^ r1[6]}, 8'd0);

    for (int i = 0; i < 500; i++) begin
      logic [7:0] g;
      case ($urandom_range(5))
        0: if (!busy) start_write(8'($urandom));
        1: begin @(negedge clk); busy = 1'b0; end
        2: partial_strobe();
        3: begin @(negedge clk); arr = 8'($urandom); end
        default: do_read(busy ? "R2 random busy read" : "R6 random ready read", g);
      endcase
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule